// File: doc/BRIEF.md
# Balanced Three-Lane Frame Encoder

This block is the transmit half of a three-lane parallel-to-serial link. Once per frame it takes a 21-bit word that was captured earlier by a load pulse. It cuts the word into three 7-bit lane words and shifts each lane out one bit per bit-rate enable. A fourth lane carries a frame-rate clock pattern.

In balanced mode each lane sends 9 bits per frame: seven data bits, then a complementary flag pair. Each lane keeps its own running sum of the ones it has sent minus the zeros. At the frame boundary the lane decides whether to send its word true or inverted, so that the sum is pulled back toward zero. The clock lane alternates between a frame with four high bits and a frame with five high bits, so its level also averages out.

In plain mode each lane sends 7 raw bits with no inversion and no flags, and the running sums are held. The mode is sampled at the first bit of each frame.

Top module: `balanced_frame_encoder`

## Requirements
- R1: After reset, all three data lanes and the clock lane output 0, every lane's running sum is zero, and the first balanced frame uses the four-high clock pattern.
- R2: A frame lasts 9 bit steps when `bal_mode` is 1 and 7 bit steps when it is 0. The mode is taken at the first bit step of a frame, and later changes to `bal_mode` inside that frame have no effect.
- R3: The outputs change only at a clock edge where `bit_en` is 1, and they hold their value otherwise.
- R4: `load` captures `din`. A frame sends the value captured most recently before its first bit step, and changes to `din` without `load` have no effect.
- R5: Lane k carries `din[7k+6:7k]`, sent least significant bit first, as frame bits 0 to 6.
- R6: In balanced mode a lane word is sent inverted exactly when the lane's running sum is nonzero and has the same sign as the word's disparity (ones minus zeros). A running sum of zero sends the word true. The running sum then adds the disparity of all 9 bits that were sent.
- R7: In balanced mode, frame bits 7 and 8 are 1,0 for a word sent true and 0,1 for a word sent inverted.
- R8: Over balanced frames, the bit-by-bit running sum of each data lane stays within ±10.
- R9: In balanced mode the clock lane sends 4 high bits then 5 low bits, and 5 high bits then 4 low bits, on alternating balanced frames. Its bit-by-bit running sum stays within ±5.
- R10: In plain mode, lanes send their 7 raw bits with no inversion. The clock lane sends 4 high bits then 3 low bits. Running sums and the clock-lane alternation are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-rate enable; one serial bit per asserted cycle |
| load | input | 1 | Captures `din` into the holding register |
| din | input | 21 | Parallel frame word |
| bal_mode | input | 1 | 1 = balanced 9-bit frames, 0 = plain 7-bit frames |
| lane_out | output | 3 | Serial data lanes, bit k is lane k |
| clk_lane | output | 1 | Serial frame-clock lane |

## Verification
The inversion rule only shows up when a lane's running sum is nonzero. The same-sign case needs a word whose disparity has the sign of that sum, and the opposite-sign case needs one that does not. The stimulus reaches both cases by sending runs of all-zero and all-one words, then alternating them, then random words, all from reset. This drives each sum from zero to its extreme values and back. It then inserts plain frames and returns to balanced mode, to show that the sums and the clock alternation survive the interruption. During frames it toggles `bal_mode` and `din` and adds idle cycles between bit steps.

// File: rtl/balanced_frame_encoder.sv
module balanced_frame_encoder #(
  parameter int LANES  = 3,
  parameter int LANE_W = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bit_en,
  input  logic                     load,
  input  logic [LANES*LANE_W-1:0]  din,
  input  logic                     bal_mode,
  output logic [LANES-1:0]         lane_out,
  output logic                     clk_lane
);
  localparam int WORD_W = LANES * LANE_W;
  localparam int FRM_W  = LANE_W + 2;
  localparam int SUM_W  = $clog2(LANE_W + 1) + 2;
  localparam int CNT_W  = $clog2(FRM_W);
  localparam int HI_A   = (FRM_W - 1) / 2;
  localparam int HI_P   = (LANE_W + 1) / 2;
  localparam logic [FRM_W-1:0] PAT_A = FRM_W'((1 << HI_A) - 1);
  localparam logic [FRM_W-1:0] PAT_B = FRM_W'((1 << (HI_A + 1)) - 1);
  localparam logic [FRM_W-1:0] PAT_P = FRM_W'((1 << HI_P) - 1);

  logic [WORD_W-1:0]      hold_q;
  logic [CNT_W-1:0]       left_q;
  logic                   phase_q;
  logic [FRM_W-1:0]       clk_sh;
  logic [LANES*SUM_W-1:0] rs_flat;
  logic                   go;

  assign go       = bit_en && (left_q == '0);
  assign clk_lane = clk_sh[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '0;
      left_q  <= '0;
      phase_q <= 1'b0;
      clk_sh  <= '0;
    end else begin
      if (load) hold_q <= din;
      if (go) begin
        left_q <= bal_mode ? CNT_W'(FRM_W - 1) : CNT_W'(LANE_W - 1);
        if (bal_mode) begin
          clk_sh  <= phase_q ? PAT_B : PAT_A;
          phase_q <= ~phase_q;
        end else begin
          clk_sh <= PAT_P;
        end
      end else if (bit_en) begin
        left_q <= left_q - 1'b1;
        clk_sh <= clk_sh >> 1;
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0]       w;
    logic [SUM_W-1:0]        ones;
    logic signed [SUM_W-1:0] disp;
    logic signed [SUM_W-1:0] rs_q;
    logic                    inv;
    logic [LANE_W-1:0]       tx;
    logic [FRM_W-1:0]        sh_q;

    assign w    = hold_q[k*LANE_W +: LANE_W];
    assign ones = SUM_W'($countones(w));
    assign disp = $signed((ones << 1) - SUM_W'(LANE_W));
    assign inv  = (rs_q != '0) && (disp[SUM_W-1] == rs_q[SUM_W-1]);
    assign tx   = inv ? ~w : w;
    assign lane_out[k] = sh_q[0];
    assign rs_flat[k*SUM_W +: SUM_W] = rs_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_q <= '0;
        rs_q <= '0;
      end else if (go) begin
        if (bal_mode) begin
          sh_q <= {inv, ~inv, tx};
          rs_q <= inv ? rs_q - disp : rs_q + disp;
        end else begin
          sh_q <= {2'b00, w};
        end
      end else if (bit_en) begin
        sh_q <= sh_q >> 1;
      end
    end
  end
endmodule

// File: rtl/balanced_frame_encoder_chk.sv
module balanced_frame_encoder_chk #(
  parameter int LANES  = 3,
  parameter int LANE_W = 7,
  parameter int SUM_W  = 5,
  parameter int CNT_W  = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bit_en,
  input logic                     bal_mode,
  input logic                     go,
  input logic [LANES-1:0]         lane_out,
  input logic                     clk_lane,
  input logic                     phase_q,
  input logic [CNT_W-1:0]         left_q,
  input logic [LANES*SUM_W-1:0]   rs_flat
);
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(lane_out) && $stable(clk_lane)));

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= CNT_W'(LANE_W + 1));

  a_r9_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (go && bal_mode) |=> (phase_q != $past(phase_q)));

  a_r10_phase_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(go && bal_mode) |=> $stable(phase_q));

  a_r10_sum_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(go && bal_mode) |=> $stable(rs_flat));

  for (genvar k = 0; k < LANES; k++) begin : g_sum
    logic signed [SUM_W-1:0] s;
    assign s = rs_flat[k*SUM_W +: SUM_W];
    a_r8_word_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (s <= SUM_W'(LANE_W)) && (s >= -SUM_W'(LANE_W)));
  end
endmodule

bind balanced_frame_encoder balanced_frame_encoder_chk #(
  .LANES(LANES), .LANE_W(LANE_W), .SUM_W(SUM_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bal_mode(bal_mode), .go(go),
  .lane_out(lane_out), .clk_lane(clk_lane), .phase_q(phase_q),
  .left_q(left_q), .rs_flat(rs_flat)
);

// File: tb/sim_balanced_frame_encoder.sv
`timescale 1ns/1ps
module sim_balanced_frame_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        load = 1'b0;
  logic [20:0] din = '0;
  logic        bal_mode = 1'b1;
  logic [2:0]  lane_out;
  logic        clk_lane;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  balanced_frame_encoder u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .load(load), .din(din),
    .bal_mode(bal_mode), .lane_out(lane_out), .clk_lane(clk_lane)
  );

  typedef struct {
    logic [2:0] lanes;
    logic       ck;
    bit         bal;
    int         idx;
  } item_t;

  item_t exp_q[$];
  int    rs_m[3] = '{0, 0, 0};
  bit    phase_m = 1'b0;
  bit    mon_on = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic send_frame(input logic [20:0] word, input bit bal, input int gap);
    int len;
    logic [8:0] seq[3];
    logic [8:0] cpat;
    len = bal ? 9 : 7;
    @(negedge clk); din = ~word; load = 1'b1;
    @(negedge clk); din = word;
    @(negedge clk); load = 1'b0; din = word ^ 21'h15A5A5; bal_mode = bal;
    for (int k = 0; k < 3; k++) begin
      logic [6:0] w;
      int d;
      bit inv;
      w = word[7*k +: 7];
      d = 2 * $countones(w) - 7;
      if (bal) begin
        inv = (rs_m[k] != 0) && ((d < 0) == (rs_m[k] < 0));
        seq[k] = {inv, ~inv, inv ? ~w : w};
        rs_m[k] = inv ? rs_m[k] - d : rs_m[k] + d;
      end else begin
        seq[k] = {2'b00, w};
      end
    end
    if (bal) begin
      cpat = phase_m ? 9'h01F : 9'h00F;
      phase_m = ~phase_m;
    end else begin
      cpat = 9'h00F;
    end
    for (int i = 0; i < len; i++) begin
      item_t it;
      it.lanes = {seq[2][i], seq[1][i], seq[0][i]};
      it.ck = cpat[i];
      it.bal = bal;
      it.idx = i;
      exp_q.push_back(it);
    end
    for (int i = 0; i < len; i++) begin
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      if (i == 1) bal_mode = ~bal;
      if (i == len - 2) bal_mode = bal;
      repeat (gap) @(negedge clk);
    end
  endtask

  initial begin : monitor
    logic [2:0] last_l;
    logic       last_c;
    int ds[3];
    int cs;
    last_l = '0; last_c = 1'b0; cs = 0;
    for (int k = 0; k < 3; k++) ds[k] = 0;
    wait (mon_on);
    forever begin
      @(posedge clk);
      if (bit_en) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", 1, 0);
        end else begin
          item_t it;
          string rq;
          it = exp_q.pop_front();
          rq = !it.bal ? "R10" : (it.idx >= 7) ? "R7" : "R6";
          check(lane_out === it.lanes, rq, lane_out, it.lanes);
          check(clk_lane === it.ck, it.bal ? "R9" : "R10", clk_lane, it.ck);
          if (it.bal) begin
            for (int k = 0; k < 3; k++) begin
              ds[k] += lane_out[k] ? 1 : -1;
              check(ds[k] <= 10 && ds[k] >= -10, "R8", ds[k], 10);
            end
            cs += clk_lane ? 1 : -1;
            check(cs <= 5 && cs >= -5, "R9", cs, 5);
          end
        end
        last_l = lane_out; last_c = clk_lane;
      end else begin
        @(negedge clk);
        check(lane_out === last_l && clk_lane === last_c, "R3",
              {lane_out, clk_lane}, {last_l, last_c});
      end
    end
  end

  initial begin : watchdog
    #500000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(lane_out === 3'b000 && clk_lane === 1'b0, "R1", {lane_out, clk_lane}, 0);
    mon_on = 1'b1;
    // R1 R4 R5: first frames from zero sums, word true
    send_frame(21'h0, 1'b1, 0);
    send_frame(21'h0, 1'b1, 1);
    send_frame(21'h0, 1'b1, 0);
    send_frame(21'h1FFFFF, 1'b1, 0);
    send_frame(21'h1FFFFF, 1'b1, 2);
    for (int i = 0; i < 6; i++) send_frame((i % 2) ? 21'h1FFFFF : 21'h0, 1'b1, 0);
    send_frame(21'h0AAAAA, 1'b1, 0);
    send_frame(21'h1C3870, 1'b1, 1);
    for (int i = 0; i < 30; i++) send_frame(21'($urandom), 1'b1, $urandom_range(0, 2));
    // R10: plain frames leave sums and clock phase alone
    send_frame(21'h12345, 1'b0, 0);
    send_frame(21'h1FFFFF, 1'b0, 1);
    for (int i = 0; i < 4; i++) send_frame(21'($urandom), 1'b0, 0);
    for (int i = 0; i < 10; i++) send_frame(21'($urandom), 1'b1, $urandom_range(0, 1));
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule